// File: doc/BRIEF.md
# Real-Time Clock with Frozen Transfer Registers

This core keeps a calendar clock from seconds up to century in BCD counters that advance on a one-second tick input. The host does not read those counters directly. It reads a shadow set of clock registers. The core copies all shadow registers from the counters in one transfer on the cycle after each advance. Through a control bit, the host can stop these transfers, so that a multi-register read sees one coherent instant while the counters keep running. The same bit also allows a coherent write: time values written while transfers are stopped are loaded into the counters when the bit is cleared.

An alarm compares seconds, minutes, hours and day of month against four alarm registers. On a match it raises a flag, and a read of the flags register clears that flag. The flag can drive an active-high interrupt. The host bus is a plain synchronous register port with direct offsets and a read latency of one cycle.

Register offsets (hexadecimal): 0 seconds, 1 minutes, 2 hours, 3 day of month, 4 day of week, 5 month, 6 two-digit year, 7 century, 8 alarm seconds, 9 alarm minutes, A alarm hours, B alarm day of month, C enables, D flags, E control. Unmapped offsets read as 00.

Top module: `rtc_xfer_core`

## Requirements
- R1: After reset the clock reads 00:00:00, day of month 01, day of week 01, month 01, year 00, century 20. The control register (offset E) reads 01h, and flags and enables read 00h. The alarm_irq output is 0. Read data appears on bus_rdata in the cycle after bus_re is sampled.
- R2: Control bit 0 is the run bit (active-low stop). While it is 1, each sec_tick pulse advances the counters by one second. All shadow clock registers (offsets 0-7) then take the new time together in the following cycle.
- R3: While control bit 3 (transfer inhibit) is 1, the shadow clock registers do not change, but the counters keep counting. Clearing the bit without any host clock write in between refreshes the shadow with the current counter time at once.
- R4: Host writes to offsets 0-7 while inhibit is 1 are shown in the shadow registers. When inhibit is cleared, they are loaded into the counters, and counting continues from the written time.
- R5: If inhibit is set in the cycle right after an advance, the transfer for that advance still completes before the shadow freezes.
- R6: Host writes to offsets 0-7 while inhibit is 0 are ignored.
- R7: Seconds and minutes roll over after 59, hours after 23, and months after 12. Day of week counts 1 to 7 and returns to 1. Year 99 carries into the century register.
- R8: Day of month rolls over after the month length: 30 for April, June, September and November; 31 for the other long months; 29 for February in a leap year, else 28. A year is a leap year when it is divisible by 4, except year 00 of a century not divisible by 4.
- R9: When an advance produces a time whose seconds, minutes, hours and day of month all equal the alarm registers, flags bit 0 becomes 1. A read of the flags register returns the flag and clears it.
- R10: alarm_irq is 1 exactly while flags bit 0 and enables bit 0 (alarm interrupt enable) are both 1. Enables bit 1 (alarm backup enable) is stored and read back, and has no other effect.
- R11: While the run bit is 0, sec_tick pulses are ignored and the time does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, one cycle after bus_re |
| alarm_irq | output | 1 | Active-high alarm interrupt |

## Verification
A broken carry or month-length decode shows in the shadow registers one cycle after the tick that crosses the boundary. For this reason the bench sets the time just before each boundary and reads every field after a single tick. An inhibit path that loses time or drops a pending transfer shows only when inhibit is released, as a second value that is too low or too high on the first read after the release. A stuck alarm flag shows on the second flags read and on alarm_irq within one cycle.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int BW  = 8;
  localparam int NTF = 8;
  typedef logic [BW-1:0]           bcd_t;
  typedef bcd_t [NTF-1:0]          tvec_t;

  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_MDAY = 3;
  localparam int F_WDAY = 4;
  localparam int F_MON  = 5;
  localparam int F_YEAR = 6;
  localparam int F_CENT = 7;

  localparam int A_ALM0 = 8;
  localparam int A_ALM3 = 11;
  localparam int A_ENA  = 12;
  localparam int A_FLAG = 13;
  localparam int A_CTRL = 14;

  localparam int CTRL_RUN = 0;
  localparam int CTRL_INH = 3;
  localparam int ENA_AIE  = 0;
  localparam int ENA_ABE  = 1;

  localparam tvec_t T_RST = {8'h20, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

  function automatic bcd_t bcd_inc(bcd_t v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [6:0] bcd2bin(bcd_t v);
    return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
  endfunction

  function automatic logic is_leap(bcd_t yr, bcd_t ce);
    logic [6:0] yb, cb;
    yb = bcd2bin(yr);
    cb = bcd2bin(ce);
    return (yb[1:0] == 2'd0) && ((yb != 7'd0) || (cb[1:0] == 2'd0));
  endfunction

  function automatic bcd_t month_len(bcd_t mo, logic leap);
    case (mo)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_time_counter.sv
module rtc_time_counter
  import rtc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  adv,
  input  logic  load,
  input  tvec_t load_val,
  output tvec_t cnt_q,
  output tvec_t cnt_nxt
);
  tvec_t cnt_d;
  logic  cy;

  always_comb begin
    cnt_nxt = cnt_q;
    cy      = 1'b1;
    if (cnt_q[F_SEC] == 8'h59) cnt_nxt[F_SEC] = 8'h00;
    else begin cnt_nxt[F_SEC] = bcd_inc(cnt_q[F_SEC]); cy = 1'b0; end
    if (cy) begin
      if (cnt_q[F_MIN] == 8'h59) cnt_nxt[F_MIN] = 8'h00;
      else begin cnt_nxt[F_MIN] = bcd_inc(cnt_q[F_MIN]); cy = 1'b0; end
    end
    if (cy) begin
      if (cnt_q[F_HOUR] == 8'h23) cnt_nxt[F_HOUR] = 8'h00;
      else begin cnt_nxt[F_HOUR] = bcd_inc(cnt_q[F_HOUR]); cy = 1'b0; end
    end
    if (cy) begin
      cnt_nxt[F_WDAY] = (cnt_q[F_WDAY] == 8'h07) ? 8'h01 : bcd_inc(cnt_q[F_WDAY]);
      if (cnt_q[F_MDAY] == month_len(cnt_q[F_MON], is_leap(cnt_q[F_YEAR], cnt_q[F_CENT])))
        cnt_nxt[F_MDAY] = 8'h01;
      else begin cnt_nxt[F_MDAY] = bcd_inc(cnt_q[F_MDAY]); cy = 1'b0; end
    end
    if (cy) begin
      if (cnt_q[F_MON] == 8'h12) cnt_nxt[F_MON] = 8'h01;
      else begin cnt_nxt[F_MON] = bcd_inc(cnt_q[F_MON]); cy = 1'b0; end
    end
    if (cy) begin
      if (cnt_q[F_YEAR] == 8'h99) cnt_nxt[F_YEAR] = 8'h00;
      else begin cnt_nxt[F_YEAR] = bcd_inc(cnt_q[F_YEAR]); cy = 1'b0; end
    end
    if (cy) begin
      cnt_nxt[F_CENT] = (cnt_q[F_CENT] == 8'h99) ? 8'h00 : bcd_inc(cnt_q[F_CENT]);
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    if (load)     cnt_d = load_val;
    else if (adv) cnt_d = cnt_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= T_RST;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit
  import rtc_pkg::*;
#(
  parameter int NALM = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [$clog2(NALM)-1:0] wr_sel,
  input  bcd_t                    wr_data,
  input  logic                    adv,
  input  tvec_t                   cnt_nxt,
  output bcd_t [NALM-1:0]         alm_q,
  output logic                    hit
);
  bcd_t [NALM-1:0] alm_d;
  logic [NALM-1:0] fld_eq;

  for (genvar i = 0; i < NALM; i++) begin : g_cmp
    assign fld_eq[i] = (alm_q[i] == cnt_nxt[i]);
  end

  assign hit = adv && (&fld_eq);

  always_comb begin
    alm_d = alm_q;
    if (wr_en) alm_d[wr_sel] = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) alm_q <= '0;
    else        alm_q <= alm_d;
  end
endmodule

// File: rtl/rtc_xfer_core.sv
module rtc_xfer_core
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BW-1:0]     bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [BW-1:0]     bus_rdata,
  output logic              alarm_irq
);
  localparam int NALM = 4;
  localparam int TIW  = $clog2(NTF);
  localparam int AIW  = $clog2(NALM);
  localparam logic [ADDR_W-1:0] AD_NTF  = ADDR_W'(NTF);
  localparam logic [ADDR_W-1:0] AD_ALM0 = ADDR_W'(A_ALM0);
  localparam logic [ADDR_W-1:0] AD_ALM3 = ADDR_W'(A_ALM3);
  localparam logic [ADDR_W-1:0] AD_ENA  = ADDR_W'(A_ENA);
  localparam logic [ADDR_W-1:0] AD_FLAG = ADDR_W'(A_FLAG);
  localparam logic [ADDR_W-1:0] AD_CTRL = ADDR_W'(A_CTRL);

  logic [1:0] rs_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  logic            inh_q, inh_d, run_q, run_d;
  logic            aie_q, aie_d, abe_q, abe_d;
  logic            af_q, af_d, pend_q, pend_d, dirty_q, dirty_d;
  tvec_t           shadow_q, shadow_d;
  logic [BW-1:0]   rdata_d;
  tvec_t           cnt_q, cnt_nxt;
  bcd_t [NALM-1:0] alm_q;
  logic            adv, load, hit;
  logic            wr_time, wr_ctrl, wr_alm, inh_clear;

  assign adv       = sec_tick && run_q;
  assign wr_time   = bus_we && (bus_addr < AD_NTF);
  assign wr_ctrl   = bus_we && (bus_addr == AD_CTRL);
  assign wr_alm    = bus_we && (bus_addr >= AD_ALM0) && (bus_addr <= AD_ALM3);
  assign inh_clear = wr_ctrl && inh_q && !bus_wdata[CTRL_INH];
  assign load      = inh_clear && dirty_q;

  rtc_time_counter u_cnt (
    .clk(clk), .rst_n(rst_int_n), .adv(adv), .load(load),
    .load_val(shadow_q), .cnt_q(cnt_q), .cnt_nxt(cnt_nxt)
  );

  rtc_alarm_unit #(.NALM(NALM)) u_alm (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_alm), .wr_sel(bus_addr[AIW-1:0]),
    .wr_data(bus_wdata), .adv(adv), .cnt_nxt(cnt_nxt), .alm_q(alm_q), .hit(hit)
  );

  always_comb begin
    shadow_d = shadow_q;
    if (pend_q) shadow_d = cnt_q;
    else if (wr_time && inh_q) shadow_d[bus_addr[TIW-1:0]] = bus_wdata;

    pend_d = (adv && !inh_q) || (inh_clear && !dirty_q);

    dirty_d = dirty_q;
    if (wr_time && inh_q && !pend_q) dirty_d = 1'b1;
    if (inh_clear)                   dirty_d = 1'b0;

    inh_d = inh_q;
    run_d = run_q;
    if (wr_ctrl) begin
      inh_d = bus_wdata[CTRL_INH];
      run_d = bus_wdata[CTRL_RUN];
    end

    aie_d = aie_q;
    abe_d = abe_q;
    if (bus_we && (bus_addr == AD_ENA)) begin
      aie_d = bus_wdata[ENA_AIE];
      abe_d = bus_wdata[ENA_ABE];
    end

    af_d = af_q;
    if (hit)                                   af_d = 1'b1;
    else if (bus_re && (bus_addr == AD_FLAG))  af_d = 1'b0;

    rdata_d = bus_rdata;
    if (bus_re) begin
      rdata_d = '0;
      if (bus_addr < AD_NTF)                                 rdata_d = shadow_q[bus_addr[TIW-1:0]];
      else if ((bus_addr >= AD_ALM0) && (bus_addr <= AD_ALM3)) rdata_d = alm_q[bus_addr[AIW-1:0]];
      else if (bus_addr == AD_ENA) begin
        rdata_d[ENA_AIE] = aie_q;
        rdata_d[ENA_ABE] = abe_q;
      end
      else if (bus_addr == AD_FLAG) rdata_d[0] = af_q;
      else if (bus_addr == AD_CTRL) begin
        rdata_d[CTRL_INH] = inh_q;
        rdata_d[CTRL_RUN] = run_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      shadow_q  <= T_RST;
      pend_q    <= 1'b0;
      dirty_q   <= 1'b0;
      inh_q     <= 1'b0;
      run_q     <= 1'b1;
      aie_q     <= 1'b0;
      abe_q     <= 1'b0;
      af_q      <= 1'b0;
      bus_rdata <= '0;
    end else begin
      shadow_q  <= shadow_d;
      pend_q    <= pend_d;
      dirty_q   <= dirty_d;
      inh_q     <= inh_d;
      run_q     <= run_d;
      aie_q     <= aie_d;
      abe_q     <= abe_d;
      af_q      <= af_d;
      bus_rdata <= rdata_d;
    end
  end

  assign alarm_irq = af_q && aie_q;
endmodule

// File: rtl/rtc_xfer_core_chk.sv
module rtc_xfer_core_chk
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_int_n,
  input logic              inh_q,
  input logic              pend_q,
  input logic              run_q,
  input logic              load,
  input logic              hit,
  input logic              af_q,
  input logic              bus_we,
  input logic              bus_re,
  input logic [ADDR_W-1:0] bus_addr,
  input tvec_t             cnt_q,
  input tvec_t             shadow_q
);
  localparam logic [ADDR_W-1:0] AD_NTF  = ADDR_W'(NTF);
  localparam logic [ADDR_W-1:0] AD_FLAG = ADDR_W'(A_FLAG);

  a_r3_frozen_shadow: assert property (@(posedge clk) disable iff (!rst_int_n)
    (inh_q && !pend_q && !(bus_we && (bus_addr < AD_NTF))) |=> $stable(shadow_q));

  a_r5_pending_copy: assert property (@(posedge clk) disable iff (!rst_int_n)
    pend_q |=> (shadow_q == $past(cnt_q)));

  a_r11_stopped: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!run_q && !load) |=> $stable(cnt_q));

  a_r9_flag_clear: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_re && (bus_addr == AD_FLAG) && !hit) |=> !af_q);

  a_r9_flag_set: assert property (@(posedge clk) disable iff (!rst_int_n)
    hit |=> af_q);
endmodule

bind rtc_xfer_core rtc_xfer_core_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_int_n(rst_int_n), .inh_q(inh_q), .pend_q(pend_q), .run_q(run_q),
  .load(load), .hit(hit), .af_q(af_q), .bus_we(bus_we), .bus_re(bus_re),
  .bus_addr(bus_addr), .cnt_q(cnt_q), .shadow_q(shadow_q)
);

// File: tb/rtc_xfer_core_tb_top.sv
module rtc_xfer_core_tb_top;
  localparam int AW = 4;

  logic          clk, rst_n, sec_tick, bus_we, bus_re, alarm_irq;
  logic [AW-1:0] bus_addr;
  logic [7:0]    bus_wdata, bus_rdata;
  int            total, bad;

  rtc_xfer_core #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
    .bus_rdata(bus_rdata), .alarm_irq(alarm_irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rdchk(string req, logic [3:0] a, logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic tick();
    @(negedge clk);
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
  endtask

  task automatic set_time(logic [7:0] s, logic [7:0] m, logic [7:0] h, logic [7:0] md,
                          logic [7:0] wd, logic [7:0] mo, logic [7:0] y, logic [7:0] c);
    wr(4'hE, 8'h09);
    wr(4'h0, s);  wr(4'h1, m);  wr(4'h2, h);  wr(4'h3, md);
    wr(4'h4, wd); wr(4'h5, mo); wr(4'h6, y);  wr(4'h7, c);
    wr(4'hE, 8'h01);
  endtask

  task automatic t_reset();
    chk("R1 irq", {7'd0, alarm_irq}, 8'h00);
    rdchk("R1 sec", 4'h0, 8'h00);
    rdchk("R1 mday", 4'h3, 8'h01);
    rdchk("R1 wday", 4'h4, 8'h01);
    rdchk("R1 month", 4'h5, 8'h01);
    rdchk("R1 century", 4'h7, 8'h20);
    rdchk("R1 ctrl", 4'hE, 8'h01);
    rdchk("R1 flags", 4'hD, 8'h00);
    rdchk("R1 enables", 4'hC, 8'h00);
  endtask

  task automatic t_tick();
    tick();
    rdchk("R2 one tick", 4'h0, 8'h01);
    tick(); tick();
    rdchk("R2 three ticks", 4'h0, 8'h03);
    rdchk("R2 minutes", 4'h1, 8'h00);
  endtask

  task automatic t_ignored();
    wr(4'h0, 8'h45);
    rdchk("R6 write ignored", 4'h0, 8'h03);
  endtask

  task automatic t_inhibit();
    set_time(8'h10, 8'h00, 8'h08, 8'h05, 8'h02, 8'h03, 8'h21, 8'h20);
    wr(4'hE, 8'h09);
    tick(); tick(); tick();
    rdchk("R3 frozen", 4'h0, 8'h10);
    rdchk("R3 ctrl inhibit", 4'hE, 8'h09);
    wr(4'hE, 8'h01);
    rdchk("R3 refreshed", 4'h0, 8'h13);
  endtask

  task automatic t_load();
    wr(4'hE, 8'h09);
    wr(4'h1, 8'h42);
    wr(4'h0, 8'h07);
    rdchk("R4 shadow shows write", 4'h0, 8'h07);
    wr(4'hE, 8'h01);
    tick();
    rdchk("R4 loaded sec", 4'h0, 8'h08);
    rdchk("R4 loaded min", 4'h1, 8'h42);
  endtask

  task automatic t_midxfer();
    @(negedge clk);
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
    bus_addr = 4'hE; bus_wdata = 8'h09; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    rdchk("R5 transfer completed", 4'h0, 8'h09);
    tick();
    rdchk("R5 frozen after", 4'h0, 8'h09);
    wr(4'hE, 8'h01);
    rdchk("R5 release", 4'h0, 8'h10);
  endtask

  task automatic t_rollover();
    set_time(8'h59, 8'h59, 8'h23, 8'h31, 8'h07, 8'h12, 8'h99, 8'h19);
    tick();
    rdchk("R7 sec", 4'h0, 8'h00);
    rdchk("R7 min", 4'h1, 8'h00);
    rdchk("R7 hour", 4'h2, 8'h00);
    rdchk("R7 mday", 4'h3, 8'h01);
    rdchk("R7 wday", 4'h4, 8'h01);
    rdchk("R7 month", 4'h5, 8'h01);
    rdchk("R7 year", 4'h6, 8'h00);
    rdchk("R7 century", 4'h7, 8'h20);
  endtask

  task automatic month_case(string tag, logic [7:0] md, logic [7:0] mo, logic [7:0] y,
                            logic [7:0] c, logic [7:0] emd, logic [7:0] emo);
    set_time(8'h59, 8'h59, 8'h23, md, 8'h03, mo, y, c);
    tick();
    rdchk({"R8 mday ", tag}, 4'h3, emd);
    rdchk({"R8 month ", tag}, 4'h5, emo);
  endtask

  task automatic t_month();
    month_case("2024", 8'h28, 8'h02, 8'h24, 8'h20, 8'h29, 8'h02);
    month_case("2023", 8'h28, 8'h02, 8'h23, 8'h20, 8'h01, 8'h03);
    month_case("2100", 8'h28, 8'h02, 8'h00, 8'h21, 8'h01, 8'h03);
    month_case("2000", 8'h28, 8'h02, 8'h00, 8'h20, 8'h29, 8'h02);
    month_case("april", 8'h30, 8'h04, 8'h25, 8'h20, 8'h01, 8'h05);
  endtask

  task automatic t_stop();
    set_time(8'h20, 8'h10, 8'h01, 8'h02, 8'h01, 8'h01, 8'h30, 8'h20);
    wr(4'hE, 8'h00);
    rdchk("R11 ctrl stopped", 4'hE, 8'h00);
    tick(); tick();
    rdchk("R11 no advance", 4'h0, 8'h20);
    wr(4'hE, 8'h01);
    tick();
    rdchk("R11 resumed from held", 4'h0, 8'h21);
  endtask

  task automatic t_alarm();
    set_time(8'h58, 8'h30, 8'h12, 8'h15, 8'h03, 8'h06, 8'h24, 8'h20);
    wr(4'h8, 8'h59); wr(4'h9, 8'h30); wr(4'hA, 8'h12); wr(4'hB, 8'h15);
    rdchk("R9 alarm hour readback", 4'hA, 8'h12);
    wr(4'hC, 8'h01);
    rdchk("R10 enables", 4'hC, 8'h01);
    chk("R10 irq idle", {7'd0, alarm_irq}, 8'h00);
    tick();
    @(negedge clk);
    chk("R10 irq raised", {7'd0, alarm_irq}, 8'h01);
    rdchk("R9 flag set", 4'hD, 8'h01);
    chk("R10 irq cleared", {7'd0, alarm_irq}, 8'h00);
    rdchk("R9 flag cleared", 4'hD, 8'h00);
    tick();
    rdchk("R9 no match", 4'hD, 8'h00);
    wr(4'hC, 8'h02);
    wr(4'h8, 8'h01); wr(4'h9, 8'h31);
    tick();
    @(negedge clk);
    chk("R10 irq masked", {7'd0, alarm_irq}, 8'h00);
    rdchk("R9 flag masked", 4'hD, 8'h01);
    rdchk("R10 backup bit", 4'hC, 8'h02);
  endtask

  initial begin
    #1_000_000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0; bad = 0;
    rst_n = 1'b0; sec_tick = 1'b0; bus_we = 1'b0; bus_re = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_tick();
    t_ignored();
    t_inhibit();
    t_load();
    t_midxfer();
    t_rollover();
    t_month();
    t_stop();
    t_alarm();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule